// File: doc/BRIEF.md
# Coprocessor Instruction Decode Dispatcher

This block sits next to a CPU's decode stage and sees every decoded instruction word at the same moment the CPU decoder does. When the CPU reports that it does not know the word, the dispatcher compares it against a small programmable table of user-defined opcodes. It also checks a fixed floating-point opcode group, which is filtered by a per-subgroup enable mask. If either matches, the dispatcher raises a claim combinationally in that same cycle. With no claim, the CPU takes its illegal-instruction path.

A claimed word is latched together with its two operands and offered to a coprocessor port. It stays there until the coprocessor signals completion, or until an interrupt flushes it. The class of each claimed instruction sets the CPU-side behaviour:

- An autonomous instruction lets the CPU keep issuing.
- A blocking instruction stalls the CPU and holds off interrupts until it completes.
- A non-blocking instruction stalls the CPU, but lets an interrupt in, and the interrupt flushes the coprocessor operation.

When the matched entry asks for write-back, the coprocessor result is passed to the CPU in the completion cycle.

Top module: `cop_dispatch`

## Requirements
- R1: `claim_o` is a combinational function of the current decode inputs. It is 1 exactly when `dec_valid_i` is 1, `cpu_hit_i` is 0, and the word matches a table entry or an enabled floating-point subgroup. Otherwise it is 0.
- R2: A table entry is 20 bits: bit 19 valid, [18:13] primary opcode, [12:3] extended opcode, [2:1] class, [0] write-back flag. An entry matches when it is valid, its primary equals word bits [31:26] and its extended equals word bits [10:1]. When several entries match, the lowest index wins.
- R3: A configuration write (`cfg_we_i`, `cfg_idx_i`, `cfg_wdata_i`) replaces one entry. The new entry takes effect from the next cycle. Reset loads the `RST_TABLE` values; by default entry 0 = valid, primary 4, extended 16, autonomous, write-back, and all other entries are invalid.
- R4: A word with primary opcode `FP_PRI` (default 59) and no table match is claimed only if `fp_en_i` bit [word bits 2:1] is 1. Such a claim is non-blocking with no write-back. A table match takes precedence over this floating-point rule.
- R5: On a claim, `claim_cls_o` gives the class (0 autonomous, 1 blocking, 2 non-blocking) and `claim_wb_o` gives the write-back flag. Both are 0 without a claim.
- R6: After reset `cop_valid_o` is 0. A claim while no operation is outstanding raises `cop_valid_o` in the next cycle, with the word and both operands on the coprocessor outputs. These hold unchanged until completion or flush.
- R7: While an autonomous operation is outstanding, `stall_o` is 0 unless a new claim arrives. A claim during any outstanding operation raises `stall_o` in that cycle and is not issued.
- R8: While a blocking or non-blocking operation is outstanding, `stall_o` is 1. With nothing outstanding, `stall_o`, `irq_hold_o` and `flush_o` are 0.
- R9: While a blocking operation is outstanding, `irq_hold_o` is 1, and `irq_i` never causes a flush.
- R10: While a non-blocking operation is outstanding, `irq_i` = 1 with `cop_done_i` = 0 gives `flush_o` = 1 in that cycle, and `cop_valid_o` = 0 in the next. If completion and an interrupt come together, completion wins and there is no flush.
- R11: `cop_done_i` during an outstanding operation ends it in the next cycle. In that done cycle, `res_valid_o` equals the operation's write-back flag and `res_data_o` carries `cop_result_i`. Otherwise `res_valid_o` is 0 and `res_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decode stage holds a word |
| dec_insn_i | input | 32 | Decoded instruction word |
| cpu_hit_i | input | 1 | CPU decoder recognised the word |
| dec_op_a_i | input | DATA_W | First operand from the CPU |
| dec_op_b_i | input | DATA_W | Second operand from the CPU |
| fp_en_i | input | FP_GROUPS | Floating-point subgroup enable mask |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_idx_i | input | clog2(NUM_UDI) | Entry index to write |
| cfg_wdata_i | input | 20 | New entry contents |
| claim_o | output | 1 | Same-cycle claim of the word |
| claim_cls_o | output | 2 | Class of the claimed word |
| claim_wb_o | output | 1 | Claimed word returns a result |
| stall_o | output | 1 | CPU must hold issue |
| irq_i | input | 1 | Asynchronous interrupt pending |
| irq_hold_o | output | 1 | Interrupts must be held off |
| flush_o | output | 1 | Outstanding operation is flushed |
| cop_valid_o | output | 1 | Operation offered to coprocessor |
| cop_insn_o | output | 32 | Word of the outstanding operation |
| cop_op_a_o | output | DATA_W | First operand to coprocessor |
| cop_op_b_o | output | DATA_W | Second operand to coprocessor |
| cop_done_i | input | 1 | Coprocessor completion |
| cop_result_i | input | DATA_W | Coprocessor result |
| res_valid_o | output | 1 | Result write-back to CPU register |
| res_data_o | output | DATA_W | Write-back data |

## Verification
Decode is driven with four kinds of word:
- words the CPU already owns, which separate the CPU-hit gate from the table match;
- unknown words, which must fall through to the fault path;
- words that hit two table entries at once, which expose the index priority;
- floating-point words in enabled and disabled subgroups, including one shadowed by a table entry.

Each class is then run against interrupts arriving alone and together with completion, which tells the flush path apart from the hold-off path. A second claim arriving while an autonomous operation is outstanding shows that it stalls rather than overwrites. Configuration writes made in the same cycle as a matching word show when an entry change takes effect. A long stretch of mixed random traffic is compared cycle by cycle against a behavioural model.

// File: rtl/cop_dispatch_pkg.sv
package cop_dispatch_pkg;
  localparam int INSN_W = 32;
  localparam int PRI_W  = 6;
  localparam int EXT_W  = 10;

  typedef enum logic [1:0] {
    CLS_AUTO   = 2'd0,
    CLS_BLOCK  = 2'd1,
    CLS_NONBLK = 2'd2,
    CLS_RSVD   = 2'd3
  } cls_e;

  typedef struct packed {
    logic             vld;
    logic [PRI_W-1:0] pri;
    logic [EXT_W-1:0] ext;
    cls_e             cls;
    logic             wb;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);
endpackage

// File: rtl/cop_match_table.sv
module cop_match_table
  import cop_dispatch_pkg::*;
#(
  parameter int                       NUM_UDI   = 4,
  parameter logic [NUM_UDI*ENT_W-1:0] RST_TABLE = '0,
  localparam int                      IDX_W     = $clog2(NUM_UDI)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  ent_t             cfg_wdata_i,
  input  logic [PRI_W-1:0] pri_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic             hit_o,
  output cls_e             cls_o,
  output logic             wb_o
);
  logic [NUM_UDI-1:0] match;
  logic [NUM_UDI-1:0] wb_v;
  cls_e               cls_v [NUM_UDI];

  for (genvar g = 0; g < NUM_UDI; g++) begin : g_ent
    ent_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ent_q <= ent_t'(RST_TABLE[g*ENT_W +: ENT_W]);
      else if (cfg_we_i && cfg_idx_i == IDX_W'(g)) ent_q <= cfg_wdata_i;
    end
    assign match[g] = ent_q.vld && (ent_q.pri == pri_i) && (ent_q.ext == ext_i);
    assign cls_v[g] = ent_q.cls;
    assign wb_v[g]  = ent_q.wb;
  end

  assign hit_o = |match;

  // lowest index wins
  always_comb begin
    cls_o = CLS_AUTO;
    wb_o  = 1'b0;
    for (int i = NUM_UDI - 1; i >= 0; i--) begin
      if (match[i]) begin
        cls_o = cls_v[i];
        wb_o  = wb_v[i];
      end
    end
  end
endmodule

// File: rtl/cop_fp_decode.sv
module cop_fp_decode
  import cop_dispatch_pkg::*;
#(
  parameter int               FP_GROUPS = 4,
  parameter logic [PRI_W-1:0] FP_PRI    = 6'd59,
  localparam int              GRP_W     = $clog2(FP_GROUPS),
  localparam int              PAD_N     = 1 << GRP_W
) (
  input  logic [PRI_W-1:0]     pri_i,
  input  logic [GRP_W-1:0]     grp_i,
  input  logic [FP_GROUPS-1:0] fp_en_i,
  output logic                 hit_o
);
  typedef logic [PAD_N-1:0] pad_t;
  pad_t en_pad;

  assign en_pad = pad_t'(fp_en_i);
  assign hit_o  = (pri_i == FP_PRI) && en_pad[grp_i];
endmodule

// File: rtl/cop_issue_ctrl.sv
module cop_issue_ctrl
  import cop_dispatch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              claim_i,
  input  cls_e              cls_i,
  input  logic              wb_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              irq_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              busy_o,
  output cls_e              busy_cls_o,
  output logic [INSN_W-1:0] insn_o,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output logic              stall_o,
  output logic              irq_hold_o,
  output logic              flush_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o
);
  logic              busy_q, wb_q;
  cls_e              cls_q;
  logic [INSN_W-1:0] insn_q;
  logic [DATA_W-1:0] a_q, b_q;

  assign flush_o = busy_q && (cls_q == CLS_NONBLK) && irq_i && !done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wb_q   <= 1'b0;
      cls_q  <= CLS_AUTO;
      insn_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (busy_q) begin
      if (done_i || flush_o) busy_q <= 1'b0;
    end else if (claim_i) begin
      busy_q <= 1'b1;
      wb_q   <= wb_i;
      cls_q  <= cls_i;
      insn_q <= insn_i;
      a_q    <= op_a_i;
      b_q    <= op_b_i;
    end
  end

  // a claim while busy is held back by the stall
  assign stall_o     = busy_q && ((cls_q != CLS_AUTO) || claim_i);
  assign irq_hold_o  = busy_q && (cls_q == CLS_BLOCK);
  assign res_valid_o = busy_q && done_i && wb_q;
  assign res_data_o  = res_valid_o ? result_i : '0;
  assign busy_o      = busy_q;
  assign busy_cls_o  = cls_q;
  assign insn_o      = insn_q;
  assign op_a_o      = a_q;
  assign op_b_o      = b_q;
endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch
  import cop_dispatch_pkg::*;
#(
  parameter int                       NUM_UDI   = 4,
  parameter int                       FP_GROUPS = 4,
  parameter int                       DATA_W    = 32,
  parameter logic [PRI_W-1:0]         FP_PRI    = 6'd59,
  parameter logic [NUM_UDI*ENT_W-1:0] RST_TABLE =
    {{((NUM_UDI-1)*ENT_W){1'b0}}, ENT_W'({1'b1, 6'd4, 10'd16, 2'd0, 1'b1})},
  localparam int                      IDX_W     = $clog2(NUM_UDI),
  localparam int                      GRP_W     = $clog2(FP_GROUPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dec_valid_i,
  input  logic [INSN_W-1:0]    dec_insn_i,
  input  logic                 cpu_hit_i,
  input  logic [DATA_W-1:0]    dec_op_a_i,
  input  logic [DATA_W-1:0]    dec_op_b_i,
  input  logic [FP_GROUPS-1:0] fp_en_i,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [ENT_W-1:0]     cfg_wdata_i,
  output logic                 claim_o,
  output logic [1:0]           claim_cls_o,
  output logic                 claim_wb_o,
  output logic                 stall_o,
  input  logic                 irq_i,
  output logic                 irq_hold_o,
  output logic                 flush_o,
  output logic                 cop_valid_o,
  output logic [INSN_W-1:0]    cop_insn_o,
  output logic [DATA_W-1:0]    cop_op_a_o,
  output logic [DATA_W-1:0]    cop_op_b_o,
  input  logic                 cop_done_i,
  input  logic [DATA_W-1:0]    cop_result_i,
  output logic                 res_valid_o,
  output logic [DATA_W-1:0]    res_data_o
);
  logic             udi_hit, udi_wb, fp_hit, sel_wb;
  cls_e             udi_cls, sel_cls, busy_cls;
  logic [PRI_W-1:0] pri;

  assign pri = dec_insn_i[INSN_W-1 -: PRI_W];

  cop_match_table #(.NUM_UDI(NUM_UDI), .RST_TABLE(RST_TABLE)) u_tbl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i,
    .cfg_wdata_i (ent_t'(cfg_wdata_i)),
    .pri_i       (pri),
    .ext_i       (dec_insn_i[EXT_W:1]),
    .hit_o       (udi_hit),
    .cls_o       (udi_cls),
    .wb_o        (udi_wb)
  );

  cop_fp_decode #(.FP_GROUPS(FP_GROUPS), .FP_PRI(FP_PRI)) u_fp (
    .pri_i   (pri),
    .grp_i   (dec_insn_i[1 +: GRP_W]),
    .fp_en_i,
    .hit_o   (fp_hit)
  );

  // table has precedence over floating-point decode
  assign sel_cls     = udi_hit ? udi_cls : CLS_NONBLK;
  assign sel_wb      = udi_hit && udi_wb;
  assign claim_o     = dec_valid_i && !cpu_hit_i && (udi_hit || fp_hit);
  assign claim_cls_o = claim_o ? 2'(sel_cls) : 2'd0;
  assign claim_wb_o  = claim_o && sel_wb;

  cop_issue_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .claim_i     (claim_o),
    .cls_i       (sel_cls),
    .wb_i        (sel_wb),
    .insn_i      (dec_insn_i),
    .op_a_i      (dec_op_a_i),
    .op_b_i      (dec_op_b_i),
    .irq_i,
    .done_i      (cop_done_i),
    .result_i    (cop_result_i),
    .busy_o      (cop_valid_o),
    .busy_cls_o  (busy_cls),
    .insn_o      (cop_insn_o),
    .op_a_o      (cop_op_a_o),
    .op_b_o      (cop_op_b_o),
    .stall_o,
    .irq_hold_o,
    .flush_o,
    .res_valid_o,
    .res_data_o
  );
endmodule

// File: rtl/cop_dispatch_chk.sv
module cop_dispatch_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              claim_i,
  input logic [31:0]       dec_insn_i,
  input logic              cop_valid_i,
  input logic [31:0]       cop_insn_i,
  input logic [DATA_W-1:0] cop_op_a_i,
  input logic              stall_i,
  input logic              irq_hold_i,
  input logic              flush_i,
  input logic              irq_i,
  input logic              done_i,
  input logic              res_valid_i,
  input logic [1:0]        busy_cls_i
);
  AST_ISSUE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i && !cop_valid_i |=> cop_valid_i && cop_insn_i == $past(dec_insn_i)); // R6
  AST_PAYLOAD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_valid_i && !done_i && !flush_i |=> cop_valid_i && $stable(cop_insn_i) && $stable(cop_op_a_i)); // R6
  AST_AUTO_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_valid_i && busy_cls_i == 2'd0 && !claim_i |-> !stall_i); // R7
  AST_BUSY_CLAIM_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_valid_i && claim_i |-> stall_i); // R7
  AST_NONAUTO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_valid_i && busy_cls_i != 2'd0 |-> stall_i); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cop_valid_i |-> !stall_i && !irq_hold_i && !flush_i); // R8
  AST_BLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_valid_i && busy_cls_i == 2'd1 |-> irq_hold_i && !flush_i); // R9
  AST_FLUSH_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> cop_valid_i && busy_cls_i == 2'd2 && irq_i && !done_i); // R10
  AST_FLUSH_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !cop_valid_i); // R10
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_valid_i && done_i |=> !cop_valid_i); // R11
  AST_RES_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> cop_valid_i && done_i); // R11
endmodule

bind cop_dispatch cop_dispatch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .claim_i     (claim_o),
  .dec_insn_i  (dec_insn_i),
  .cop_valid_i (cop_valid_o),
  .cop_insn_i  (cop_insn_o),
  .cop_op_a_i  (cop_op_a_o),
  .stall_i     (stall_o),
  .irq_hold_i  (irq_hold_o),
  .flush_i     (flush_o),
  .irq_i       (irq_i),
  .done_i      (cop_done_i),
  .res_valid_i (res_valid_o),
  .busy_cls_i  (busy_cls)
);

// File: tb/cop_dispatch_tb.sv
module cop_dispatch_tb_top;
  localparam int NU = 4;
  localparam int NG = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          dec_valid = 0, cpu_hit = 0, cfg_we = 0, irq = 0, done = 0;
  logic [31:0]   dec_insn = '0, op_a = '0, op_b = '0, result = '0;
  logic [NG-1:0] fp_en = '0;
  logic [1:0]    cfg_idx = '0;
  logic [19:0]   cfg_wdata = '0;
  logic          claim_o, claim_wb_o, stall_o, irq_hold_o, flush_o, cop_valid_o, res_valid_o;
  logic [1:0]    claim_cls_o;
  logic [31:0]   cop_insn_o, cop_op_a_o, cop_op_b_o, res_data_o;

  cop_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(dec_valid), .dec_insn_i(dec_insn),
    .cpu_hit_i(cpu_hit), .dec_op_a_i(op_a), .dec_op_b_i(op_b), .fp_en_i(fp_en),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .claim_o(claim_o), .claim_cls_o(claim_cls_o), .claim_wb_o(claim_wb_o),
    .stall_o(stall_o), .irq_i(irq), .irq_hold_o(irq_hold_o), .flush_o(flush_o),
    .cop_valid_o(cop_valid_o), .cop_insn_o(cop_insn_o), .cop_op_a_o(cop_op_a_o),
    .cop_op_b_o(cop_op_b_o), .cop_done_i(done), .cop_result_i(result),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );

  // reference model state
  logic [19:0] m_tbl [NU];
  bit          m_busy, m_wb;
  logic [1:0]  m_cls;
  logic [31:0] m_insn, m_a, m_b;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  function automatic logic [31:0] mk(int p, int e);
    return {6'(p), 15'd0, 10'(e), 1'b0};
  endfunction

  function automatic logic [19:0] ent(bit v, int p, int e, int c, bit w);
    return {v, 6'(p), 10'(e), 2'(c), w};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NU; i++) m_tbl[i] = '0;
    m_tbl[0] = ent(1, 4, 16, 0, 1);
    m_busy = 0; m_wb = 0; m_cls = 0; m_insn = '0; m_a = '0; m_b = '0;
  endtask

  // sample mid-cycle, compare, then advance the model at the edge
  task automatic tick();
    bit hit, w, e_claim, e_stall, e_hold, e_flush, e_res;
    logic [1:0] c;
    hit = 0; w = 0; c = 0;
    #2;
    for (int i = 0; i < NU; i++)
      if (!hit && m_tbl[i][19] && m_tbl[i][18:13] == dec_insn[31:26] && m_tbl[i][12:3] == dec_insn[10:1]) begin
        hit = 1; c = m_tbl[i][2:1]; w = m_tbl[i][0];
      end
    if (!hit && dec_insn[31:26] == 6'd59 && fp_en[dec_insn[2:1]]) begin
      hit = 1; c = 2; w = 0;
    end
    e_claim = dec_valid && !cpu_hit && hit;
    e_stall = m_busy && (m_cls != 0 || e_claim);
    e_hold  = m_busy && m_cls == 1;
    e_flush = m_busy && m_cls == 2 && irq && !done;
    e_res   = m_busy && done && m_wb;
    chk("R1", "claim", claim_o, e_claim);
    chk("R5", "claim_cls", claim_cls_o, e_claim ? c : 2'd0);
    chk("R5", "claim_wb", claim_wb_o, e_claim && w);
    chk("R7/R8", "stall", stall_o, e_stall);
    chk("R9", "irq_hold", irq_hold_o, e_hold);
    chk("R10", "flush", flush_o, e_flush);
    chk("R6", "cop_valid", cop_valid_o, m_busy);
    if (m_busy) begin
      chk("R6", "cop_insn", cop_insn_o, m_insn);
      chk("R6", "cop_op_a", cop_op_a_o, m_a);
      chk("R6", "cop_op_b", cop_op_b_o, m_b);
    end
    chk("R11", "res_valid", res_valid_o, e_res);
    chk("R11", "res_data", res_data_o, e_res ? result : 32'd0);
    @(posedge clk);
    if (!rst_ni) model_reset();
    else begin
      if (cfg_we) m_tbl[cfg_idx] = cfg_wdata;
      if (m_busy) begin
        if (done || e_flush) m_busy = 0;
      end else if (e_claim) begin
        m_busy = 1; m_cls = c; m_wb = w; m_insn = dec_insn; m_a = op_a; m_b = op_b;
      end
    end
    @(negedge clk);
  endtask

  task automatic present(logic [31:0] w, bit hit);
    dec_valid = 1; dec_insn = w; cpu_hit = hit;
    op_a = $urandom; op_b = $urandom;
  endtask

  task automatic idle();
    dec_valid = 0; cpu_hit = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(7));
    model_reset();
    @(negedge clk);
    tick(); tick();
    rst_ni = 1;
    tick();                                        // reset state, R6

    // R3 preset entry 0, autonomous with write-back
    present(mk(4, 16), 0); #1;
    chk("R3", "preset claim", {claim_o, claim_cls_o, claim_wb_o}, {1'b1, 2'd0, 1'b1});
    tick();
    present(mk(4, 16), 0); #1;                     // second claim while busy
    chk("R7", "busy claim stalls", stall_o, 1'b1);
    tick();
    idle(); #1;
    chk("R7", "autonomous no stall", stall_o, 1'b0);
    tick();
    done = 1; result = 32'hCAFE_0001; #1;
    chk("R11", "result forwarded", {res_valid_o, res_data_o}, {1'b1, 32'hCAFE_0001});
    tick();
    done = 0; tick();

    // R1 CPU-owned and unknown words
    present(mk(4, 16), 1); #1;
    chk("R1", "cpu hit not claimed", claim_o, 1'b0);
    tick();
    present(mk(9, 3), 0); #1;
    chk("R1", "unknown not claimed", claim_o, 1'b0);
    tick();

    // R3 write takes effect next cycle
    cfg_we = 1; cfg_idx = 1; cfg_wdata = ent(1, 5, 33, 1, 0);
    present(mk(5, 33), 0); #1;
    chk("R3", "write not yet visible", claim_o, 1'b0);
    tick();
    idle(); cfg_idx = 3; cfg_wdata = ent(1, 5, 33, 2, 1); tick();
    cfg_idx = 2; cfg_wdata = ent(1, 5, 34, 2, 1); tick();
    cfg_we = 0;

    // R2 priority, R9 blocking hold-off
    present(mk(5, 33), 0); #1;
    chk("R2", "lowest index wins", {claim_o, claim_cls_o}, {1'b1, 2'd1});
    tick();
    idle(); irq = 1; #1;
    chk("R9", "hold without flush", {irq_hold_o, flush_o, stall_o}, 3'b101);
    tick(); tick();
    done = 1; tick();
    done = 0; irq = 0; tick();

    // R10 non-blocking flush
    present(mk(5, 34), 0); tick();
    idle(); irq = 1; #1;
    chk("R10", "flush on irq", flush_o, 1'b1);
    tick();
    irq = 0; #1;
    chk("R10", "flushed op gone", cop_valid_o, 1'b0);
    tick();
    present(mk(5, 34), 0); tick();
    idle(); irq = 1; done = 1; result = 32'h1234_5678; #1;
    chk("R10", "done beats irq", {flush_o, res_valid_o}, 2'b01);
    tick();
    irq = 0; done = 0; tick();

    // R4 floating-point subgroups
    fp_en = 4'b0101;
    present(mk(59, 1), 0); #1;
    chk("R4", "disabled group", claim_o, 1'b0);
    tick();
    present(mk(59, 2), 0); #1;
    chk("R4", "enabled group", {claim_o, claim_cls_o, claim_wb_o}, {1'b1, 2'd2, 1'b0});
    tick();
    idle(); done = 1; #1;
    chk("R11", "no write-back", res_valid_o, 1'b0);
    tick();
    done = 0; tick();
    cfg_we = 1; cfg_idx = 3; cfg_wdata = ent(1, 59, 2, 0, 1); tick();
    cfg_we = 0;
    present(mk(59, 2), 0); #1;
    chk("R4", "table over fp", {claim_o, claim_cls_o, claim_wb_o}, {1'b1, 2'd0, 1'b1});
    tick();
    idle(); done = 1; tick();
    done = 0;
    cfg_we = 1; cfg_idx = 1; cfg_wdata = '0; tick();
    cfg_we = 0;
    present(mk(5, 33), 0); #1;
    chk("R2", "invalid entry ignored", claim_o, 1'b0);
    tick();

    // mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int pp;
      pp = $urandom_range(0, 3);
      pp = (pp == 0) ? 4 : (pp == 1) ? 5 : (pp == 2) ? 59 : 7;
      dec_valid = ($urandom_range(0, 3) != 0);
      dec_insn  = mk(pp, $urandom_range(0, 3) + ((pp == 4) ? 16 : (pp == 5) ? 32 : 0));
      cpu_hit   = ($urandom_range(0, 4) == 0);
      op_a = $urandom; op_b = $urandom; result = $urandom;
      irq  = ($urandom_range(0, 4) == 0);
      done = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 15) == 0) fp_en = 4'($urandom);
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_idx = 2'($urandom);
      cfg_wdata = ent($urandom_range(0, 3) != 0, pp, $urandom_range(0, 3) + ((pp == 4) ? 16 : (pp == 5) ? 32 : 0),
                      $urandom_range(0, 2), 1'($urandom));
      tick();
    end
    cfg_we = 0; idle(); irq = 0; done = 0;
    tick();
    finish_run();
  end
endmodule